// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the register core of a general-purpose I/O controller. Its lines are grouped into banks of eight. Each bank has two registers. The data register holds the level that a line drives when it is an output. The direction register selects, for each line, whether it is an input or an output. Software reaches the registers over a plain 32-bit register bus made of an address, a write strobe, write data and registered read data. Any wrapper for a standard bus protocol sits outside this block.

The address map is sparse. Bank `b` starts at `(b+1)*8`, which leaves address 0 unused. The 16-byte window from 0x90 to 0x9F is kept for interrupt registers that live outside this block, so any bank whose start address would land at 0x90 or above is moved up by 0x10. Input pins pass through a two-flop synchronizer. A read of a data register returns the synchronized pin level for input lines and the stored value for output lines. Software sets a line's data bit first and then clears its direction bit, so the line drives the prepared level from the moment it becomes an output.

Top module: `gpio_bankfile`

## Requirements
- R1: GPIO line N belongs to bank N/8 and uses bit N%8 of that bank's data and direction registers.
- R2: Bank b's data register sits at word address A=(b+1)*8, raised by 0x10 when A is 0x90 or more, and its direction register sits at A+4. Only these exact addresses hit a register, so unaligned addresses are unmapped.
- R3: After reset every direction bit is 1, every data bit is 0 and `pin_oe` is all zero.
- R4: A direction bit of 1 makes the line an input (`pin_oe` bit 0), and a direction bit of 0 makes it an output (`pin_oe` bit 1). `pin_out` always carries the stored data bit, even while the line is an input.
- R5: A write to a direction register sets `pin_oe` on the next clock edge. From that edge on, each newly enabled output drives the data bit it already held.
- R6: A data register read returns, per bit, the pin level after a two-flop synchronizer when the line is an input and the stored data bit when it is an output.
- R7: Reads from unmapped addresses return 0, including the whole 0x90–0x9F window. Writes to unmapped addresses change no register and no pin.
- R8: Bits of the last bank at or above the line count read back as 0 in both registers and ignore writes. Read data bits 31:8 are always 0.
- R9: `bus_rdata` is registered and shows the register addressed in a cycle after the following clock edge, so back-to-back reads are allowed.
- R10: The number of banks is the line count divided by 8, rounded up. Addresses beyond the last bank are unmapped.
- R11: A write to a direction register leaves the data register of that bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_LINES | Raw input pin levels |
| pin_out | output | NUM_LINES | Output levels taken from the data registers |
| pin_oe | output | NUM_LINES | Output enable per line (1 = line is an output) |

## Verification
The bench targets both edges of the reserved window. It checks bank 16 at 0x88 and bank 17 at 0xA0, and it checks that every word from 0x90 to 0x9C reads 0 and ignores writes. A decoder that forgot the 0x10 jump would alias bank 17 into the window, or would leave it unreachable. The partial last bank is written with all ones and must read back 0x0F. A missing lane mask would show stray high bits in that read and enable outputs that do not exist. The bench also switches a bank to output after loading its data, then checks that the direction write left the data intact and that each data read mixes pin levels and stored bits according to direction. A design that cleared data on a direction change, or that returned the stored value for input lines, fails these reads.

// File: rtl/gpio_bankfile_pkg.sv
package gpio_bankfile_pkg;

  localparam int unsigned LANES_PER_BANK = 8;
  localparam int unsigned HOLE_START     = 'h90;
  localparam int unsigned HOLE_SPAN      = 'h10;
  localparam int unsigned DIR_OFFSET     = 4;

  typedef logic [LANES_PER_BANK-1:0] lane_vec_t;

  // Number of banks needed for a given line count (rounded up).
  function automatic int unsigned bank_count(int unsigned lines);
    return (lines + LANES_PER_BANK - 1) / LANES_PER_BANK;
  endfunction

  // Start address of a bank, stepping over the reserved interrupt window.
  function automatic int unsigned bank_base(int unsigned bank);
    int unsigned addr;
    addr = (bank + 1) * LANES_PER_BANK;
    if (addr >= HOLE_START) addr = addr + HOLE_SPAN;
    return addr;
  endfunction

  // Lines actually present in a bank (the last one may be partial).
  function automatic int unsigned bank_lanes(int unsigned lines, int unsigned bank);
    if ((bank + 1) * LANES_PER_BANK <= lines) return LANES_PER_BANK;
    return lines - bank * LANES_PER_BANK;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bankfile_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BANKS = 19
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] data_hit,
  output logic [NUM_BANKS-1:0] dir_hit,
  output logic                 any_hit
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_dec
    localparam int unsigned BASE = bank_base(b);
    assign data_hit[b] = (addr == ADDR_W'(BASE));
    assign dir_hit[b]  = (addr == ADDR_W'(BASE + DIR_OFFSET));
  end

  assign any_hit = |{data_hit, dir_hit};

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bankfile_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data_en,
  input  logic             wr_dir_en,
  input  lane_vec_t        wdata,
  input  logic [LANES-1:0] pin_sync,
  output logic [LANES-1:0] pin_out,
  output logic [LANES-1:0] pin_oe,
  output lane_vec_t        rd_data,
  output lane_vec_t        rd_dir
);

  localparam lane_vec_t LANE_MASK = lane_vec_t'((1 << LANES) - 1);

  lane_vec_t data_q;
  lane_vec_t dir_q;
  lane_vec_t sync_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= LANE_MASK;
    end else begin
      if (wr_data_en) data_q <= wdata & LANE_MASK;
      if (wr_dir_en)  dir_q  <= wdata & LANE_MASK;
    end
  end

  assign sync_ext = lane_vec_t'(pin_sync);
  assign pin_out  = data_q[LANES-1:0];
  assign pin_oe   = ~dir_q[LANES-1:0];
  assign rd_data  = ((dir_q & sync_ext) | (~dir_q & data_q)) & LANE_MASK;
  assign rd_dir   = dir_q;

  // R11: a direction write alone leaves the stored data untouched
  assert_dir_wr_keeps_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir_en && !wr_data_en) |=> $stable(data_q));

  // R5: output enables follow the written direction one edge later
  assert_oe_follows_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_en |=> (pin_oe == ~$past(wdata[LANES-1:0])));

  // R8: lanes that do not exist never hold a one
  assert_pad_lanes_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_q & ~LANE_MASK) == '0) && ((dir_q & ~LANE_MASK) == '0));

endmodule

// File: rtl/gpio_bankfile.sv
module gpio_bankfile
  import gpio_bankfile_pkg::*;
#(
  parameter int unsigned NUM_LINES = 148,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe
);

  localparam int unsigned NUM_BANKS = bank_count(NUM_LINES);

  logic [NUM_BANKS-1:0] data_hit;
  logic [NUM_BANKS-1:0] dir_hit;
  logic                 any_hit;
  logic [NUM_LINES-1:0] pin_sync;
  lane_vec_t            bank_rd_data [NUM_BANKS];
  lane_vec_t            bank_rd_dir  [NUM_BANKS];
  lane_vec_t            rd_mux;
  lane_vec_t            rdata_q;
  logic                 unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[31:LANES_PER_BANK];

  gpio_addr_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_decode (
    .addr     (bus_addr),
    .data_hit (data_hit),
    .dir_hit  (dir_hit),
    .any_hit  (any_hit)
  );

  gpio_sync #(
    .WIDTH (NUM_LINES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned LANES = bank_lanes(NUM_LINES, b);
    localparam int unsigned LO    = b * LANES_PER_BANK;

    gpio_bank #(
      .LANES (LANES)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_data_en (bus_we & data_hit[b]),
      .wr_dir_en  (bus_we & dir_hit[b]),
      .wdata      (bus_wdata[LANES_PER_BANK-1:0]),
      .pin_sync   (pin_sync[LO +: LANES]),
      .pin_out    (pin_out[LO +: LANES]),
      .pin_oe     (pin_oe[LO +: LANES]),
      .rd_data    (bank_rd_data[b]),
      .rd_dir     (bank_rd_dir[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (data_hit[b]) rd_mux = rd_mux | bank_rd_data[b];
      if (dir_hit[b])  rd_mux = rd_mux | bank_rd_dir[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_mux;
  end

  assign bus_rdata = {{(32 - LANES_PER_BANK){1'b0}}, rdata_q};

  // R2: at most one register answers any address
  assert_decode_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_hit, dir_hit}));

  // R7: an unmapped read returns zero on the next edge
  assert_unmapped_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |=> (bus_rdata == 32'd0));

  // R7: an unmapped write moves no pin
  assert_unmapped_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !any_hit) |=> ($stable(pin_oe) && $stable(pin_out)));

endmodule

// File: tb/gpio_bankfile_test.sv
`timescale 1ns/1ps
module gpio_bankfile_test;

  localparam int NL = 148;
  localparam int NB = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] pins = '0;
  logic [NL-1:0] pin_out;
  logic [NL-1:0] pin_oe;

  always #2 clk = ~clk;

  gpio_bankfile #(.NUM_LINES(NL), .ADDR_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct {
    logic [31:0] exp;
    int          issued;
    string       tag;
  } item_t;

  item_t    sb[$];
  int       cyc = 0;
  int       n_tests = 0;
  int       n_fail = 0;
  bit       done = 0;
  logic [7:0] m_data [NB];
  logic [7:0] m_dir  [NB];

  always @(posedge clk) cyc <= cyc + 1;

  // Bench restatement of the address map: banks below 17 sit at 8b+8,
  // later banks are pushed past the 0x90..0x9F hole.
  function automatic int bbase(int b);
    return (b < 17) ? 8 * b + 8 : 8 * b + 24;
  endfunction

  function automatic logic [7:0] lane_mask(int b);
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++) if (b * 8 + i < NL) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] pins_of(int b);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) if (b * 8 + i < NL) r[i] = pins[b * 8 + i];
    return r;
  endfunction

  function automatic logic [31:0] model_read(int a);
    for (int b = 0; b < NB; b++) begin
      if (a == bbase(b))
        return {24'd0, ((m_dir[b] & pins_of(b)) | (~m_dir[b] & m_data[b])) & lane_mask(b)};
      if (a == bbase(b) + 4)
        return {24'd0, m_dir[b]};
    end
    return 32'd0;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_data[b] = 8'h00;
      m_dir[b]  = lane_mask(b);
    end
  endtask

  task automatic check(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_pins(string tag);
    logic [NL-1:0] eo;
    logic [NL-1:0] ee;
    for (int l = 0; l < NL; l++) begin
      eo[l] = m_data[l / 8][l % 8];
      ee[l] = ~m_dir[l / 8][l % 8];
    end
    check({tag, " pin_out"}, pin_out, eo);
    check({tag, " pin_oe"}, pin_oe, ee);
  endtask

  // Driver: a write, with the model following it.
  task automatic wr(int a, logic [31:0] v);
    @(negedge clk);
    bus_addr  = 12'(a);
    bus_wdata = v;
    bus_we    = 1'b1;
    for (int b = 0; b < NB; b++) begin
      if (a == bbase(b))     m_data[b] = v[7:0] & lane_mask(b);
      if (a == bbase(b) + 4) m_dir[b]  = v[7:0] & lane_mask(b);
    end
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // Driver: a read, expected value pushed to the scoreboard.
  task automatic rd(int a, string tag);
    item_t it;
    @(negedge clk);
    bus_we   = 1'b0;
    bus_addr = 12'(a);
    it.exp    = model_read(a);
    it.issued = cyc;
    it.tag    = tag;
    sb.push_back(it);
  endtask

  // Monitor: results appear one edge after the address.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].issued < cyc) begin
      item_t it;
      it = sb.pop_front();
      n_tests++;
      if (bus_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: reset state
    check_pins("R3 reset");
    rd(bbase(0) + 4, "R3 dir bank0 reset");
    rd(bbase(18) + 4, "R8 dir last bank reset");
    rd(bbase(0), "R3 data bank0 reset");

    // R1/R6: single line 77 -> bank 9 bit 5
    pins = '0;
    pins[77] = 1'b1;
    settle();
    rd(bbase(9), "R1 line77 bank9");
    rd(bbase(8), "R1 neighbour bank8");

    // R6/R2/R8: patterned inputs, back-to-back reads (R9)
    for (int i = 0; i < NL; i++) pins[i] = ((i * 7 + 3) % 5) < 2;
    settle();
    rd(bbase(0),  "R6 input bank0");
    rd(bbase(5),  "R9 back-to-back bank5");
    rd(bbase(16), "R2 bank16 at 0x88");
    rd(bbase(17), "R2 bank17 at 0xA0");
    rd(bbase(18), "R8 last bank input");

    // R4: data written to an input line shows on pin_out only
    wr(bbase(0), 32'h0000_003C);
    check_pins("R4 data on input");
    rd(bbase(0), "R6 input still reads pins");

    // R5: data first, then direction
    wr(bbase(2), 32'hFFFF_FFA5);
    wr(bbase(2) + 4, 32'h0000_000F);
    check_pins("R5 outputs enabled");
    rd(bbase(2), "R6 mixed bank2");
    rd(bbase(2) + 4, "R2 dir bank2");

    // R11: direction write keeps data
    wr(bbase(2) + 4, 32'h0000_0000);
    rd(bbase(2), "R11 data after dir write");

    // R7: reserved window
    for (int a = 'h90; a < 'hA0; a += 4) wr(a, 32'hFFFF_FFFF);
    check_pins("R7 window writes inert");
    for (int a = 'h90; a < 'hA0; a += 4) rd(a, "R7 window read");
    rd(bbase(17) + 4, "R7 bank17 dir untouched");
    rd(bbase(16) + 4, "R2 bank16 dir at 0x8C");

    // R8: partial last bank
    wr(bbase(18), 32'hFFFF_FFFF);
    wr(bbase(18) + 4, 32'h0000_0000);
    rd(bbase(18), "R8 last bank data");
    rd(bbase(18) + 4, "R8 last bank dir");
    check_pins("R8 last bank pins");

    // R10/R2: beyond the last bank and off-grid addresses
    rd('hB0, "R10 past last bank");
    rd('hB4, "R10 past last bank dir");
    rd('h00, "R2 address zero");
    rd('h0A, "R2 unaligned");

    settle();
    finish_run();
  end

endmodule